// File: doc/BRIEF.md
# Accumulator Processor with Polled Interrupts

This block is a small multicycle processor built around one 16-bit accumulator. It walks every instruction through explicit register-transfer steps. The program counter is copied into the memory address register, the word at that address lands in the instruction register, and the operand address from the instruction goes back into the address register. Operand data is captured in a memory buffer register, and the result is written into the accumulator. All traffic goes to one word-addressable synchronous memory with a single cycle of read latency. That memory holds both the program and its data.

Each instruction is 16 bits wide. The top four bits select the operation and the low twelve bits name a word address. A single level-sensitive interrupt request is tested only in the first state of every instruction, and only while interrupts are enabled. When the request is taken, the processor saves the program counter in a shadow register, disables further interrupts and continues fetching at a fixed handler address. A return instruction undoes all three steps. A halt instruction parks the processor until reset.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `halted` and `mem_we` are low. The first instruction is fetched from word address 0, and interrupts start out enabled.
- R2: An instruction is a 16-bit word with the opcode in bits [15:12] and a word address X in bits [11:0]. Its fetch presents the program counter on `mem_addr` in the third cycle of the instruction, and then the program counter advances by exactly one, wrapping at 12 bits.
- R3: Opcode 4'b0001 (load) sets the accumulator to M[X].
- R4: Opcode 4'b0010 (store) writes the accumulator to M[X]. `mem_we` is high for exactly one cycle, the sixth cycle of the instruction, with `mem_addr` = X and `mem_wdata` = accumulator.
- R5: Opcode 4'b0011 (add) sets the accumulator to (accumulator + M[X]) mod 2^16.
- R6: Opcode 4'b0100 (subtract) sets the accumulator to (accumulator - M[X]) mod 2^16.
- R7: Opcode 4'b1001 (jump) makes X the address of the next instruction fetched.
- R8: Opcode 4'b0111 (halt) raises `halted` in the sixth cycle of the instruction. From then until reset, `halted` stays high and no memory write occurs.
- R9: `irq` is sampled only in the first cycle of an instruction. If it is high there while interrupts are enabled, that instruction is fetched from word address 12'h004 instead, and the program counter it replaces is saved in a shadow register. A request that comes and goes in the middle of an instruction has no effect.
- R10: Taking an interrupt disables interrupts, so a request that is held high during the handler does not enter the handler again.
- R11: Opcode 4'b1010 (return from interrupt) reloads the program counter from the shadow register and enables interrupts again.
- R12: Load, add and subtract take 8 cycles, and store takes 6. Jump, return, halt and every opcode not listed above take 5 cycles. Unlisted opcodes change neither the accumulator nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_addr | output | 12 | Word address to memory, driven from the address register |
| mem_wdata | output | 16 | Write data, the accumulator value |
| mem_we | output | 1 | Write enable for one cycle per store |
| mem_rdata | input | 16 | Read data, valid one cycle after the address is presented |
| halted | output | 1 | High once a halt has executed |

## Verification
Almost every internal fault shows up at the memory port within one instruction. A wrong program counter or a wrong interrupt vector puts a wrong address on `mem_addr` in the next fetch cycle. A wrong accumulator shows up as wrong data at the next store. A wrong instruction length shifts every later write and fetch by whole cycles. The bench runs an instruction-level model in step with the design and compares write strobes, write data and addresses, fetch addresses and `halted` on every clock. A fault in the interrupt enable flag or in the shadow register therefore shows up as a mistimed or duplicated handler entry, or as a wrong return address.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    // opcode values held in the top field of an instruction word
    localparam int OPC_W = 4;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0011;
    localparam logic [OPC_W-1:0] OPC_SUB   = 4'b0100;
    localparam logic [OPC_W-1:0] OPC_HALT  = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_RETI  = 4'b1010;

    typedef enum logic [3:0] {
        ST_POLL,    // start of instruction: interrupt test
        ST_FETCH,   // MAR <- PC
        ST_FRD,     // instruction address on the bus
        ST_FCAP,    // read data valid: IR <- data, PC <- PC + 1
        ST_DECODE,  // MAR <- operand field, dispatch
        ST_ORD,     // operand address on the bus
        ST_OCAP,    // MBR <- data
        ST_EXEC,    // AC <- f(AC, MBR)
        ST_STORE,   // write strobe
        ST_HALT     // parked until reset
    } state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB
    } alu_op_e;

    typedef struct packed {
        logic    rd_operand;
        alu_op_e alu;
        logic    store;
        logic    jump;
        logic    halt;
        logic    reti;
    } dec_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             ctl
);

    always_comb begin
        ctl = '{rd_operand: 1'b0, alu: ALU_PASS, store: 1'b0,
                jump: 1'b0, halt: 1'b0, reti: 1'b0};
        unique case (opcode)
            OPC_LOAD: begin
                ctl.rd_operand = 1'b1;
                ctl.alu        = ALU_PASS;
            end
            OPC_ADD: begin
                ctl.rd_operand = 1'b1;
                ctl.alu        = ALU_ADD;
            end
            OPC_SUB: begin
                ctl.rd_operand = 1'b1;
                ctl.alu        = ALU_SUB;
            end
            OPC_STORE: ctl.store = 1'b1;
            OPC_JUMP:  ctl.jump  = 1'b1;
            OPC_HALT:  ctl.halt  = 1'b1;
            OPC_RETI:  ctl.reti  = 1'b1;
            default:   ;  // unlisted opcodes act as no-operation
        endcase
    end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DW = 16
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] opnd,
    output logic [DW-1:0] res
);

    always_comb begin
        unique case (op)
            ALU_ADD:  res = acc + opnd;
            ALU_SUB:  res = acc - opnd;
            default:  res = opnd;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int              DW      = 16,
    parameter int              AW      = 12,
    parameter logic [AW-1:0]   IRQ_VEC = 12'h004
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          halted
);

    localparam int OPC_LSB = AW;
    localparam int OPC_MSB = AW + OPC_W - 1;

    typedef struct packed {
        state_e        st;
        logic [AW-1:0] pc;
        logic [AW-1:0] mar;
        logic [AW-1:0] shadow;
        logic [DW-1:0] ir;
        logic [DW-1:0] mbr;
        logic [DW-1:0] ac;
        logic          ie;
    } regs_t;

    localparam regs_t REGS_RST = '{
        st:     ST_POLL,
        pc:     '0,
        mar:    '0,
        shadow: '0,
        ir:     '0,
        mbr:    '0,
        ac:     '0,
        ie:     1'b1
    };

    regs_t         q;
    regs_t         d;
    dec_t          dec;
    logic [DW-1:0] alu_res;

    acc_cpu_decode u_decode (
        .opcode (q.ir[OPC_MSB:OPC_LSB]),
        .ctl    (dec)
    );

    acc_cpu_alu #(.DW(DW)) u_alu (
        .op   (dec.alu),
        .acc  (q.ac),
        .opnd (q.mbr),
        .res  (alu_res)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_POLL: begin
                if (irq && q.ie) begin
                    d.shadow = q.pc;
                    d.pc     = IRQ_VEC;
                    d.ie     = 1'b0;
                end
                d.st = ST_FETCH;
            end
            ST_FETCH: begin
                d.mar = q.pc;
                d.st  = ST_FRD;
            end
            ST_FRD: begin
                d.st = ST_FCAP;
            end
            ST_FCAP: begin
                d.ir = mem_rdata;
                d.pc = q.pc + 1'b1;
                d.st = ST_DECODE;
            end
            ST_DECODE: begin
                d.mar = q.ir[AW-1:0];
                if (dec.rd_operand) begin
                    d.st = ST_ORD;
                end else if (dec.store) begin
                    d.st = ST_STORE;
                end else if (dec.jump) begin
                    d.pc = q.ir[AW-1:0];
                    d.st = ST_POLL;
                end else if (dec.halt) begin
                    d.st = ST_HALT;
                end else if (dec.reti) begin
                    d.pc = q.shadow;
                    d.ie = 1'b1;
                    d.st = ST_POLL;
                end else begin
                    d.st = ST_POLL;
                end
            end
            ST_ORD: begin
                d.st = ST_OCAP;
            end
            ST_OCAP: begin
                d.mbr = mem_rdata;
                d.st  = ST_EXEC;
            end
            ST_EXEC: begin
                d.ac = alu_res;
                d.st = ST_POLL;
            end
            ST_STORE: begin
                d.st = ST_POLL;
            end
            ST_HALT: begin
                d.st = ST_HALT;
            end
            default: begin
                d.st = ST_POLL;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REGS_RST;
        end else begin
            q <= d;
        end
    end

    assign mem_addr  = q.mar;
    assign mem_wdata = q.ac;
    assign mem_we    = (q.st == ST_STORE);
    assign halted    = (q.st == ST_HALT);

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int            AW      = 12,
    parameter logic [AW-1:0] IRQ_VEC = 12'h004
) (
    input logic          clk,
    input logic          rst_n,
    input logic          irq,
    input logic          mem_we,
    input logic          halted,
    input logic          at_poll,
    input logic          at_fcap,
    input logic [AW-1:0] pc,
    input logic [AW-1:0] shadow,
    input logic          ie
);

    // R8: once halted, stay halted
    p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8: no write while halted
    p_no_write_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R4: write strobe lasts one cycle
    p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R2: capture of the instruction advances the counter by one
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        at_fcap |=> pc == $past(pc) + 1'b1);

    // R9: a request seen at the poll point with interrupts on vectors
    p_irq_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (at_poll && irq && ie) |=> (pc == IRQ_VEC) && !ie);

    // R9, R10: interrupts are disabled only by an accepted request
    p_ie_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ie) |-> $past(at_poll) && $past(irq));

    // R11: re-enabling restores the saved counter
    p_reti_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ie) |-> pc == $past(shadow));

endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .IRQ_VEC(IRQ_VEC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (irq),
    .mem_we  (mem_we),
    .halted  (halted),
    .at_poll (q.st == ST_POLL),
    .at_fcap (q.st == ST_FCAP),
    .pc      (q.pc),
    .shadow  (q.shadow),
    .ie      (q.ie)
);

// File: tb/test_acc_cpu.sv
`timescale 1ns/1ps
module test_acc_cpu;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        irq;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic        halted;

    always #5 clk = ~clk;

    acc_cpu i_acc_cpu (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // bench memory with one cycle of read latency
    logic [15:0] mem [0:255];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    // reference model state
    logic [15:0] mm [0:255];
    logic [11:0] m_pc, m_shadow;
    logic [15:0] m_ac;
    logic        m_ie;
    integer      m_next, halt_from, st_cycle, fetch_cycle;
    logic [11:0] st_addr, fetch_addr;
    logic [15:0] st_data;
    integer      checks = 0, errors = 0, k;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, k, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] v);
        mem[a] = v;
        mm[a]  = v;
    endtask

    task automatic model_step();
        logic [15:0] ir;
        logic [11:0] x;
        integer len;
        if (m_ie && irq) begin            // R9 poll at instruction start
            m_shadow = m_pc;
            m_pc     = 12'h004;
            m_ie     = 1'b0;              // R10
        end
        fetch_cycle = k + 2;
        fetch_addr  = m_pc;
        ir   = mm[m_pc[7:0]];
        m_pc = m_pc + 12'd1;
        x    = ir[11:0];
        len  = 5;
        case (ir[15:12])
            4'b0001: begin m_ac = mm[x[7:0]]; len = 8; end
            4'b0011: begin m_ac = m_ac + mm[x[7:0]]; len = 8; end
            4'b0100: begin m_ac = m_ac - mm[x[7:0]]; len = 8; end
            4'b0010: begin
                mm[x[7:0]] = m_ac;
                st_cycle = k + 5; st_addr = x; st_data = m_ac; len = 6;
            end
            4'b1001: m_pc = x;
            4'b1010: begin m_pc = m_shadow; m_ie = 1'b1; end
            4'b0111: halt_from = k + 5;
            default: ;
        endcase
        m_next = k + len;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) put(i, 16'h0000);
        // vector slot and handler: count entries in 0x43, keep AC in 0x45
        put(8'h00, 16'h9010);
        put(8'h04, 16'h2045); put(8'h05, 16'h1043); put(8'h06, 16'h3044);
        put(8'h07, 16'h2043); put(8'h08, 16'h1045); put(8'h09, 16'hA000);
        // main program
        put(8'h10, 16'h1030); put(8'h11, 16'h3031); put(8'h12, 16'h2050);
        put(8'h13, 16'h4032); put(8'h14, 16'h2051); put(8'h15, 16'h5123);
        put(8'h16, 16'h2052); put(8'h17, 16'h1033); put(8'h18, 16'h2053);
        put(8'h19, 16'h901C); put(8'h1A, 16'h2054); put(8'h1B, 16'h7000);
        put(8'h1C, 16'h1034); put(8'h1D, 16'h2055); put(8'h1E, 16'h1035);
        put(8'h1F, 16'h2056); put(8'h20, 16'h7000); put(8'h21, 16'h2057);
        // data
        put(8'h30, 16'hFFF0); put(8'h31, 16'h0020); put(8'h32, 16'h0020);
        put(8'h33, 16'h1234); put(8'h34, 16'hABCD); put(8'h35, 16'h8000);
        put(8'h44, 16'h0001);

        m_pc = '0; m_shadow = '0; m_ac = '0; m_ie = 1'b1;
        m_next = 0; halt_from = -1; st_cycle = -1; fetch_cycle = -1;
        st_addr = '0; st_data = '0; fetch_addr = '0;
        k = -1;

        rst_n = 1'b0;
        irq   = 1'b0;
        repeat (3) @(negedge clk);
        chk(halted == 1'b0, "R1 halted in reset", 32'(halted), 32'd0);
        chk(mem_we == 1'b0, "R1 mem_we in reset", 32'(mem_we), 32'd0);
        rst_n = 1'b1;

        for (k = 0; k < 3000; k++) begin
            if (k > 0) @(negedge clk);
            irq = ((k >= 30) && (k < 50)) || ((k >= 95) && (k < 130));
            if (halt_from < 0 && k == m_next) model_step();
            if (k == 0) begin
                chk(halted == 1'b0, "R1 halted after reset", 32'(halted), 32'd0);
                chk(mem_we == 1'b0, "R1 mem_we after reset", 32'(mem_we), 32'd0);
            end
            chk(mem_we == (k == st_cycle), "R4 write strobe timing R12",
                32'(mem_we), 32'(k == st_cycle));
            if (k == st_cycle) begin
                chk(mem_addr == st_addr, "R4 store address", 32'(mem_addr), 32'(st_addr));
                chk(mem_wdata == st_data, "R4 store data R3 R5 R6", 32'(mem_wdata), 32'(st_data));
            end
            if (k == fetch_cycle)
                chk(mem_addr == fetch_addr, "R2 fetch address R7 R9 R11",
                    32'(mem_addr), 32'(fetch_addr));
            chk(halted == (halt_from >= 0 && k >= halt_from), "R8 halted",
                32'(halted), 32'(halt_from >= 0 && k >= halt_from));
            if (halt_from >= 0 && k >= halt_from + 20) break;
        end
        if (k >= 3000) chk(1'b0, "watchdog", 32'(k), 32'd0);

        chk(mem[8'h50] == 16'h0010, "R5 add wraps", 32'(mem[8'h50]), 32'h0010);
        chk(mem[8'h51] == 16'hFFF0, "R6 subtract wraps", 32'(mem[8'h51]), 32'hFFF0);
        chk(mem[8'h52] == 16'hFFF0, "R12 unlisted opcode keeps AC", 32'(mem[8'h52]), 32'hFFF0);
        chk(mem[8'h53] == 16'h1234, "R3 load", 32'(mem[8'h53]), 32'h1234);
        chk(mem[8'h54] == 16'h0000, "R7 jump skips", 32'(mem[8'h54]), 32'h0000);
        chk(mem[8'h55] == 16'hABCD, "R7 jump target runs", 32'(mem[8'h55]), 32'hABCD);
        chk(mem[8'h56] == 16'h8000, "R11 resumes after return", 32'(mem[8'h56]), 32'h8000);
        chk(mem[8'h57] == 16'h0000, "R8 nothing after halt", 32'(mem[8'h57]), 32'h0000);
        chk(mem[8'h43] == 16'h0002, "R9 R10 handler entries", 32'(mem[8'h43]), 32'h0002);
        chk(halted == 1'b1, "R8 halted at end", 32'(halted), 32'd1);
        for (int i = 0; i < 256; i++)
            if (mem[i] != mm[i])
                chk(1'b0, "R4 memory image", 32'(mem[i]), 32'(mm[i]));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule